// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block is the control sequencer for a small multi-cycle processor. It steps the fetch, decode and execute phases and adds interrupt entry and return around them. The datapath reports the end of each phase on `step_done`. Device requests are tested only when an execute phase completes. A priority encoder reduces up to eight device request lines to one internal request and picks the device that will be acknowledged. If that request is pending and interrupts are enabled, the sequencer leaves the normal loop. It saves the already-incremented PC in a dedicated return register, turns interrupts off and raises the acknowledge line. It then waits for the device to put a vector on the data bus.

The vector is mapped to a handler address as `HBASE + vector * HSTRIDE`. With the default values, vector 40 gives address 1000. In the same cycle that the handler address is loaded into the PC, the sequencer pushes the current mode bit onto the downward-growing system stack, makes the system stack pointer the active one and selects kernel mode. The enable-interrupts and disable-interrupts instructions take effect at the end of execute. Return-from-interrupt pops the saved mode, gives the user stack pointer back when that mode is user, reloads the PC from the return register and enables interrupts again.

States: `S_FETCH`, `S_DECODE`, `S_EXEC`, `S_INT_ACK`, `S_INT_VEC`, `S_RETI_RD`, `S_RETI_WB`. The transitions are:
- `S_FETCH`→`S_DECODE`→`S_EXEC` on `step_done`.
- `S_EXEC`→`S_FETCH` when the execute phase ends with no entry and no return.
- `S_EXEC`→`S_INT_ACK` on interrupt entry.
- `S_EXEC`→`S_RETI_RD` on a return executed in kernel mode.
- `S_INT_ACK`→`S_INT_VEC` on `vec_valid`.
- `S_INT_VEC`→`S_FETCH` and `S_RETI_RD`→`S_RETI_WB`→`S_FETCH`, each unconditionally.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the sequencer is in `S_FETCH` with `int_en`=0, `mode_user`=1 (1 = user, 0 = kernel), `inta`=0, `pc_load`=0, and `sp_active` equal to `USP_INIT`.
- R2: Requests are tested only when `step_done` ends the execute phase. If no request is pending or the effective enable is 0, control goes back to fetch and `inta` stays low.
- R3: On entry, the edge that ends execute loads `k0_out` with `pc_in`, clears `int_en` and makes `inta` high in the following cycle.
- R4: `inta` stays high until a cycle in which `vec_valid` is 1, and it is low in the next cycle.
- R5: Only the lowest-numbered active request line gets its bit of `irq_ack`. It is chosen at the moment of entry and held while `inta` is high, even if the requests change.
- R6: In the cycle after `vec_valid`, `pc_load`=1 and `pc_out` = `HBASE + vec_data*HSTRIDE` (vector 40 gives 1000 by default).
- R7: Entry from user mode writes the mode bit 1 (`stk_we`, `stk_wdata`) to address `SSP_INIT-1`, in the same cycle as the handler load. Afterwards `sp_active` = `SSP_INIT-1` and `mode_user`=0.
- R8: Enable and disable instructions set or clear `int_en` at the end of execute. The enable value that the instruction itself produces decides whether this boundary enters, so an enable with a pending request enters at once.
- R9: A return in kernel mode reads the stack at `sp_active` (`stk_re`). In the next cycle it loads `pc_out` = `k0_out`. After that cycle the mode is the popped bit, `int_en`=1, and `sp_active` is the popped pointer, or the user pointer if the popped mode is user.
- R10: A return executed in user mode is ignored: no stack read, no PC load, and mode and pointers are unchanged.
- R11: Entry from kernel mode does not swap pointers. It pushes mode bit 0 at `sp_active-1` and leaves `sp_active` there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_done | input | 1 | Current phase finished |
| op_ei | input | 1 | Decoded enable-interrupts instruction |
| op_di | input | 1 | Decoded disable-interrupts instruction |
| op_reti | input | 1 | Decoded return-from-interrupt instruction |
| pc_in | input | PC_W | Incremented PC from the datapath |
| pc_out | output | PC_W | PC value to load |
| pc_load | output | 1 | Load strobe for `pc_out` |
| k0_out | output | PC_W | Saved return PC |
| irq_req | input | N_IRQ | Device request lines |
| irq_ack | output | N_IRQ | Per-device acknowledge |
| inta | output | 1 | Acknowledge in progress |
| vec_valid | input | 1 | Vector present on the bus |
| vec_data | input | VEC_W | Vector from the device |
| stk_we | output | 1 | System stack write |
| stk_re | output | 1 | System stack read |
| stk_addr | output | SP_W | Stack address |
| stk_wdata | output | 1 | Mode bit written |
| stk_rdata | input | 1 | Mode bit read, one cycle after `stk_re` |
| mode_user | output | 1 | 1 = user, 0 = kernel |
| int_en | output | 1 | Interrupts enabled |
| sp_active | output | SP_W | Active stack pointer |

## Verification
Three request patterns are tried against the enable state. A pending request with interrupts off shows that the enable gates entry. Two requests at once, with the set changed during the acknowledge, separate lowest-index priority from a grant that follows the lines. An enable instruction together with a pending request shows whether the instruction's own effect decides the boundary. Entry from user mode and nested entry from kernel mode separate the swapping push from the non-swapping one. A return in each mode separates a real pop from an ignored instruction.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC,
        S_INT_ACK,
        S_INT_VEC,
        S_RETI_RD,
        S_RETI_WB
    } seq_state_t;

    localparam logic MODE_USER   = 1'b1;
    localparam logic MODE_KERNEL = 1'b0;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_IRQ = 8,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [N_IRQ-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;

    always_comb begin
        if (any) a_r5_lowest_wins: assert (req[idx]);
    end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
    parameter int VEC_W   = 8,
    parameter int PC_W    = 16,
    parameter int HBASE   = 200,
    parameter int HSTRIDE = 20
) (
    input  logic [VEC_W-1:0] vec,
    output logic [PC_W-1:0]  handler
);
    localparam logic [PC_W-1:0] BASE_C   = PC_W'(HBASE);
    localparam logic [PC_W-1:0] STRIDE_C = PC_W'(HSTRIDE);

    logic [PC_W-1:0] vec_ext;
    assign vec_ext = {{(PC_W - VEC_W){1'b0}}, vec};
    assign handler = BASE_C + vec_ext * STRIDE_C;
endmodule

// File: rtl/irq_sp_bank.sv
module irq_sp_bank #(
    parameter int SP_W = 16,
    parameter int USP_INIT = 600,
    parameter int SSP_INIT = 300
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter,
    input  logic            from_user,
    input  logic            leave,
    input  logic            to_user,
    output logic [SP_W-1:0] sp_act,
    output logic [SP_W-1:0] push_addr,
    output logic [SP_W-1:0] pop_addr
);
    logic [SP_W-1:0] sp_shadow;
    logic [SP_W-1:0] popped;

    assign push_addr = from_user ? (sp_shadow - 1'b1) : (sp_act - 1'b1);
    assign pop_addr  = sp_act;
    assign popped    = sp_act + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_act    <= SP_W'(USP_INIT);
            sp_shadow <= SP_W'(SSP_INIT);
        end else if (enter) begin
            sp_act <= push_addr;
            if (from_user) sp_shadow <= sp_act;
        end else if (leave) begin
            if (to_user) begin
                sp_act    <= sp_shadow;
                sp_shadow <= popped;
            end else begin
                sp_act <= popped;
            end
        end
    end

    a_r7_push_becomes_active: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> sp_act == $past(push_addr));
    a_r9_pop_lands_in_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (leave && to_user) |=> sp_shadow == $past(sp_act) + 1'b1);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int N_IRQ    = 8,
    parameter int PC_W     = 16,
    parameter int VEC_W    = 8,
    parameter int SP_W     = 16,
    parameter int USP_INIT = 600,
    parameter int SSP_INIT = 300,
    parameter int HBASE    = 200,
    parameter int HSTRIDE  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_done,
    input  logic             op_ei,
    input  logic             op_di,
    input  logic             op_reti,
    input  logic [PC_W-1:0]  pc_in,
    output logic [PC_W-1:0]  pc_out,
    output logic             pc_load,
    output logic [PC_W-1:0]  k0_out,
    input  logic [N_IRQ-1:0] irq_req,
    output logic [N_IRQ-1:0] irq_ack,
    output logic             inta,
    input  logic             vec_valid,
    input  logic [VEC_W-1:0] vec_data,
    output logic             stk_we,
    output logic             stk_re,
    output logic [SP_W-1:0]  stk_addr,
    output logic             stk_wdata,
    input  logic             stk_rdata,
    output logic             mode_user,
    output logic             int_en,
    output logic [SP_W-1:0]  sp_active
);
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    seq_state_t      state, state_nx;
    logic            req_any;
    logic [IDX_W-1:0] req_idx, gnt_q;
    logic [VEC_W-1:0] vec_q;
    logic [PC_W-1:0] handler;
    logic            ie_eff, take, reti_ok, exec_end;
    logic [SP_W-1:0] push_addr, pop_addr;
    logic            sp_enter, sp_leave;

    irq_prio_enc #(.N_IRQ(N_IRQ)) u_prio (
        .req(irq_req), .any(req_any), .idx(req_idx));

    irq_vec_map #(.VEC_W(VEC_W), .PC_W(PC_W), .HBASE(HBASE), .HSTRIDE(HSTRIDE)) u_map (
        .vec(vec_q), .handler(handler));

    irq_sp_bank #(.SP_W(SP_W), .USP_INIT(USP_INIT), .SSP_INIT(SSP_INIT)) u_sp (
        .clk(clk), .rst_n(rst_n),
        .enter(sp_enter), .from_user(mode_user),
        .leave(sp_leave), .to_user(stk_rdata),
        .sp_act(sp_active), .push_addr(push_addr), .pop_addr(pop_addr));

    assign exec_end = (state == S_EXEC) && step_done;
    assign ie_eff   = op_di ? 1'b0 : (op_ei ? 1'b1 : int_en);
    assign reti_ok  = op_reti && (mode_user == MODE_KERNEL);
    assign take     = ie_eff && req_any;
    assign sp_enter = (state == S_INT_VEC);
    assign sp_leave = (state == S_RETI_WB);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_FETCH:   if (step_done) state_nx = S_DECODE;
            S_DECODE:  if (step_done) state_nx = S_EXEC;
            S_EXEC:    if (step_done) begin
                           if (reti_ok)   state_nx = S_RETI_RD;
                           else if (take) state_nx = S_INT_ACK;
                           else           state_nx = S_FETCH;
                       end
            S_INT_ACK: if (vec_valid) state_nx = S_INT_VEC;
            S_INT_VEC: state_nx = S_FETCH;
            S_RETI_RD: state_nx = S_RETI_WB;
            S_RETI_WB: state_nx = S_FETCH;
            default:   state_nx = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en    <= 1'b0;
            mode_user <= MODE_USER;
            k0_out    <= '0;
            gnt_q     <= '0;
            vec_q     <= '0;
        end else begin
            if (exec_end && !reti_ok) begin
                int_en <= ie_eff;
                if (take) begin
                    k0_out <= pc_in;
                    int_en <= 1'b0;
                    gnt_q  <= req_idx;
                end
            end
            if (state == S_INT_ACK && vec_valid) vec_q <= vec_data;
            if (state == S_INT_VEC) mode_user <= MODE_KERNEL;
            if (state == S_RETI_WB) begin
                mode_user <= stk_rdata;
                int_en    <= 1'b1;
            end
        end
    end

    always_comb begin
        inta      = 1'b0;
        pc_load   = 1'b0;
        pc_out    = '0;
        stk_we    = 1'b0;
        stk_re    = 1'b0;
        stk_addr  = '0;
        stk_wdata = 1'b0;
        unique case (state)
            S_INT_ACK: inta = 1'b1;
            S_INT_VEC: begin
                pc_load   = 1'b1;
                pc_out    = handler;
                stk_we    = 1'b1;
                stk_addr  = push_addr;
                stk_wdata = mode_user;
            end
            S_RETI_RD: begin
                stk_re   = 1'b1;
                stk_addr = pop_addr;
            end
            S_RETI_WB: begin
                pc_load = 1'b1;
                pc_out  = k0_out;
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < N_IRQ; g++) begin : g_ack
        assign irq_ack[g] = inta && (gnt_q == IDX_W'(g));
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!int_en && mode_user && !inta && !pc_load));
    a_r3_entry_disables: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inta) |-> (!int_en && k0_out == $past(pc_in)));
    a_r4_inta_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && vec_valid) |=> !inta);
    a_r4_inta_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !vec_valid) |=> inta);
    a_r5_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack) && (inta == (irq_ack != '0)));
    a_r7_kernel_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> !mode_user);
    a_r9_enabled_after_return: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !stk_we) |=> int_en);
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 16;
    localparam int SP_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_done = 1'b0, op_ei = 1'b0, op_di = 1'b0, op_reti = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic [PC_W-1:0] pc_out, k0_out;
    logic pc_load;
    logic [7:0] irq_req = '0;
    logic [7:0] irq_ack;
    logic inta;
    logic vec_valid = 1'b0;
    logic [7:0] vec_data = '0;
    logic stk_we, stk_re, stk_wdata;
    logic stk_rdata = 1'b0;
    logic [SP_W-1:0] stk_addr, sp_active;
    logic mode_user, int_en;

    logic smem [0:511];
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (stk_we) smem[stk_addr[8:0]] <= stk_wdata;
        if (stk_re) stk_rdata <= smem[stk_addr[8:0]];
    end

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .step_done(step_done),
        .op_ei(op_ei), .op_di(op_di), .op_reti(op_reti),
        .pc_in(pc_in), .pc_out(pc_out), .pc_load(pc_load), .k0_out(k0_out),
        .irq_req(irq_req), .irq_ack(irq_ack), .inta(inta),
        .vec_valid(vec_valid), .vec_data(vec_data),
        .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
        .mode_user(mode_user), .int_en(int_en), .sp_active(sp_active));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_instr(input logic [PC_W-1:0] pc, input logic ei, input logic di, input logic rt);
        pc_in = pc; op_ei = ei; op_di = di; op_reti = rt; step_done = 1'b1;
        repeat (3) @(negedge clk);
        step_done = 1'b0; op_ei = 1'b0; op_di = 1'b0; op_reti = 1'b0;
    endtask

    task automatic give_vector(input logic [7:0] v);
        vec_valid = 1'b1; vec_data = v;
        @(negedge clk);
        vec_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 int_en", int_en, 0);
        check("R1 mode_user", mode_user, 1);
        check("R1 inta", inta, 0);
        check("R1 pc_load", pc_load, 0);
        check("R1 sp_active", sp_active, 600);
    endtask

    task automatic t_disabled_pending;
        irq_req = 8'b0000_0100;
        do_instr(16'd100, 0, 0, 0);
        check("R2 no inta while disabled", inta, 0);
        @(negedge clk);
        check("R2 still no inta", inta, 0);
        irq_req = '0;
    endtask

    task automatic t_enable;
        do_instr(16'd101, 1, 0, 0);
        check("R8 enable sets int_en", int_en, 1);
        check("R2 no request no entry", inta, 0);
    endtask

    task automatic t_entry_user;
        irq_req = 8'b0000_0110;
        do_instr(16'd20000, 0, 0, 0);
        check("R3 inta raised", inta, 1);
        check("R3 k0 saved", k0_out, 20000);
        check("R3 int_en cleared", int_en, 0);
        check("R5 lowest acked", irq_ack, 8'b0000_0010);
        irq_req = 8'b0000_0100;
        @(negedge clk);
        @(negedge clk);
        check("R4 inta held", inta, 1);
        check("R5 grant latched", irq_ack, 8'b0000_0010);
        give_vector(8'd40);
        check("R4 inta dropped", inta, 0);
        check("R6 pc_load", pc_load, 1);
        check("R6 handler 40->1000", pc_out, 1000);
        check("R7 push write", stk_we, 1);
        check("R7 push addr", stk_addr, 299);
        check("R7 pushed user bit", stk_wdata, 1);
        @(negedge clk);
        check("R7 kernel mode", mode_user, 0);
        check("R7 system sp", sp_active, 299);
        check("R6 load one cycle", pc_load, 0);
    endtask

    task automatic t_nested_entry;
        do_instr(16'd1001, 1, 0, 0);
        check("R8 enable enters at once", inta, 1);
        check("R11 k0 nested", k0_out, 1001);
        give_vector(8'd3);
        check("R6 handler 3->260", pc_out, 260);
        check("R11 push addr", stk_addr, 298);
        check("R11 pushed kernel bit", stk_wdata, 0);
        irq_req = '0;
        @(negedge clk);
        check("R11 no swap", sp_active, 298);
        check("R11 still kernel", mode_user, 0);
    endtask

    task automatic t_return_kernel;
        do_instr(16'd270, 0, 0, 1);
        check("R9 stack read", stk_re, 1);
        check("R9 read addr", stk_addr, 298);
        @(negedge clk);
        check("R9 pc_load", pc_load, 1);
        check("R9 pc from k0", pc_out, 1001);
        @(negedge clk);
        check("R9 mode kernel kept", mode_user, 0);
        check("R9 int_en", int_en, 1);
        check("R9 sp popped", sp_active, 299);
    endtask

    task automatic t_return_user;
        do_instr(16'd1002, 0, 0, 1);
        check("R9 read addr outer", stk_addr, 299);
        @(negedge clk);
        check("R9 pc_load outer", pc_load, 1);
        @(negedge clk);
        check("R9 mode user", mode_user, 1);
        check("R9 user sp back", sp_active, 600);
        check("R9 int_en outer", int_en, 1);
    endtask

    task automatic t_return_in_user;
        do_instr(16'd500, 0, 0, 1);
        check("R10 no read", stk_re, 0);
        check("R10 no load", pc_load, 0);
        @(negedge clk);
        check("R10 no load later", pc_load, 0);
        check("R10 mode", mode_user, 1);
        check("R10 sp", sp_active, 600);
    endtask

    task automatic t_disable;
        do_instr(16'd501, 0, 1, 0);
        check("R8 disable clears", int_en, 0);
        irq_req = 8'b1000_0000;
        do_instr(16'd502, 0, 0, 0);
        check("R2 pending ignored after disable", inta, 0);
        check("R2 no ack", irq_ack, 0);
        irq_req = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled_pending();
        t_enable();
        t_entry_user();
        t_nested_entry();
        t_return_kernel();
        t_return_user();
        t_return_in_user();
        t_disable();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule